// File: doc/BRIEF.md
# Packet Reordering Jitter Buffer

This block is the receive-side playout buffer for one emulated TDM circuit carried over a packet network. Each arriving packet carries a 16-bit sequence number and a fixed-size payload, presented as one wide word in a single cycle. The payload is stored in a circular set of slots. The slot is chosen by the low bits of the sequence number, so packets that arrive out of order are still played out in sequence order.

A byte strobe at the TDM rate pulls one byte at a time out of the head slot. The block waits for half the configured depth to fill before it starts playout. When the packet due for playout is missing and later packets are already buffered, the block conceals the whole payload. It uses either a programmable conditioning byte or a repeat of the last byte it played. When the buffer runs dry, it emits conditioning data and goes back to waiting for half fill. Four event counters track lost, out-of-window, duplicate and underrun events.

The depth in slots, the payload length in bytes, the concealment mode and the conditioning byte are configuration inputs. They are held stable while traffic flows.

Top module: `pkt_jitter_buffer`

## Requirements
- R1: After reset, `outValid` is 0, all four counters read 0, and the block is in the prefill state.
- R2: A packet is stored in slot `wrSeq` mod `SLOTS`. Payloads are played out in increasing sequence order, whatever their arrival order.
- R3: Acceptance window: an arriving packet is accepted only if (`wrSeq` − next playout sequence) mod 2^16 < `cfgDepth`. Otherwise it is dropped and `cntLate` increments. The first packet after reset is always accepted and sets the next playout sequence.
- R4: A packet whose slot still holds an unplayed payload is discarded. `cntDup` increments, and the stored payload is left unchanged.
- R5: Playout starts once the number of buffered packets reaches max(1, `cfgDepth`/2). Until then, each strobe yields `cfgCondByte`.
- R6: Each `playTick` gives `outValid` high for one cycle on the following clock, carrying one byte. A payload plays out as `cfgPayLen` bytes, byte k taken from `wrPayload[8k+7:8k]`, for k = 0 upward.
- R7: If the head packet is missing while other packets are buffered, `cntLost` increments once. `cfgPayLen` concealment bytes are emitted, and playout moves on to the next sequence number.
- R8: The concealment byte is `cfgCondByte` when `cfgRepeat` = 0. It is the last byte played from real data when `cfgRepeat` = 1.
- R9: If the head packet is missing and the buffer is empty at a packet boundary, the output is `cfgCondByte` and `cntUnder` increments. The block returns to prefill and keeps the same next playout sequence.
- R10: A packet carrying the sequence number currently being played out is counted in `cntLate` and dropped. This applies while that packet's payload is part-way through playout, or in a cycle with `playTick` high.
- R11: Sequence comparison wraps modulo 2^16, so playout continues seamlessly from 16'hFFFF to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgDepth | input | $clog2(SLOTS+1) | Window depth in packets, 1..SLOTS |
| cfgPayLen | input | $clog2(PAY_BYTES+1) | Payload length in bytes, 1..PAY_BYTES |
| cfgRepeat | input | 1 | Concealment mode: 0 conditioning byte, 1 repeat last byte |
| cfgCondByte | input | 8 | Conditioning byte |
| wrValid | input | 1 | Packet present this cycle |
| wrSeq | input | 16 | Packet sequence number |
| wrPayload | input | 8*PAY_BYTES | Payload, byte 0 in the low bits |
| playTick | input | 1 | TDM byte strobe |
| outValid | output | 1 | Output byte valid |
| outByte | output | 8 | Played-out byte |
| cntLost | output | CNT_W | Concealed lost packets |
| cntLate | output | CNT_W | Out-of-window drops |
| cntDup | output | CNT_W | Duplicate drops |
| cntUnder | output | CNT_W | Underrun events |

## Verification
The assertions assume that `cfgDepth` and `cfgPayLen` stay within their legal ranges and do not change between resets. They also assume that at most one packet arrives per cycle, and that `playTick` is low during reset. The stimulus changes depth and length only while reset is held, and changes the concealment mode only between strobes. It presents every packet as a single-cycle pulse, spaced by idle cycles so that the prefill-to-playout transition has settled before the next strobe. Scenarios cover reordering, window drops on both sides, duplicates, both concealment modes, an arrival that collides with the packet under playout, underrun recovery and sequence wrap.

// File: rtl/pkt_jitter_buffer_pkg.sv
package pkt_jitter_buffer_pkg;

  // Source of the next output byte
  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_COND = 2'd1,
    SRC_LAST = 2'd2
  } outSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrEn;   // store payload into wrSlot, mark valid
    logic    clrEn;  // head slot fully played, mark empty
    logic    outEn;  // register one output byte
    outSrc_e outSrc;
  } stb_t;

endpackage

// File: rtl/pkt_jitter_buffer_data.sv
module pkt_jitter_buffer_data
  import pkt_jitter_buffer_pkg::*;
#(
  parameter int SLOTS     = 16,
  parameter int PAY_BYTES = 8,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BYTE_W   = (PAY_BYTES > 1) ? $clog2(PAY_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  stb_t                   stb,
  input  logic [SLOT_W-1:0]      wrSlot,
  input  logic [PAY_BYTES*8-1:0] wrWord,
  input  logic [SLOT_W-1:0]      playSlot,
  input  logic [BYTE_W-1:0]      byteSel,
  input  logic [7:0]             condByte,
  output logic                   wrSlotValid,
  output logic                   playSlotValid,
  output logic                   outValid,
  output logic [7:0]             outByte
);

  logic [PAY_BYTES*8-1:0] mem [SLOTS];
  logic [SLOTS-1:0]       slotValid;
  logic [7:0]             headByte;
  logic [7:0]             lastByte;

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrSlot] <= wrWord;
  end

  // One occupancy flag per slot
  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotValid[g] <= 1'b0;
        end else if (stb.wrEn && wrSlot == SLOT_W'(g)) begin
          slotValid[g] <= 1'b1;
        end else if (stb.clrEn && playSlot == SLOT_W'(g)) begin
          slotValid[g] <= 1'b0;
        end
      end
    end
  endgenerate

  assign wrSlotValid   = slotValid[wrSlot];
  assign playSlotValid = slotValid[playSlot];
  assign headByte      = mem[playSlot][{byteSel, 3'b000} +: 8];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outByte  <= 8'h00;
      lastByte <= 8'h00;
    end else begin
      outValid <= stb.outEn;
      if (stb.outEn) begin
        unique case (stb.outSrc)
          SRC_DATA: begin
            outByte  <= headByte;
            lastByte <= headByte;
          end
          SRC_LAST: outByte <= lastByte;
          default:  outByte <= condByte;
        endcase
      end
    end
  end

endmodule

// File: rtl/pkt_jitter_buffer_ctrl.sv
module pkt_jitter_buffer_ctrl
  import pkt_jitter_buffer_pkg::*;
#(
  parameter int SLOTS     = 16,
  parameter int PAY_BYTES = 8,
  parameter int SEQ_W     = 16,
  parameter int CNT_W     = 16,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BYTE_W   = (PAY_BYTES > 1) ? $clog2(PAY_BYTES) : 1,
  localparam int DEPTH_W  = $clog2(SLOTS + 1),
  localparam int LEN_W    = $clog2(PAY_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DEPTH_W-1:0] cfgDepth,
  input  logic [LEN_W-1:0]   cfgPayLen,
  input  logic               cfgRepeat,
  input  logic               wrValid,
  input  logic [SEQ_W-1:0]   wrSeq,
  input  logic               playTick,
  input  logic               wrSlotValid,
  input  logic               playSlotValid,
  output stb_t               stb,
  output logic [SLOT_W-1:0]  wrSlot,
  output logic [SLOT_W-1:0]  playSlot,
  output logic [BYTE_W-1:0]  byteSel,
  output logic               playing,
  output logic [DEPTH_W-1:0] fillCnt,
  output logic [CNT_W-1:0]   cntLost,
  output logic [CNT_W-1:0]   cntLate,
  output logic [CNT_W-1:0]   cntDup,
  output logic [CNT_W-1:0]   cntUnder
);

  logic [SEQ_W-1:0]   nextSeq;
  logic               anchored;
  logic               curMiss;
  logic [BYTE_W-1:0]  byteIdx;

  logic [SEQ_W-1:0]   baseSeq, seqDiff;
  logic [DEPTH_W-1:0] halfDepth, startLvl;
  logic inWindow, locked, hitsHead, acceptable;
  logic doWrite, isDup, isLate;
  logic atHead, missing, underrun, stepping, lastHit, finishing, lostEvt;

  // Arrival side: modulo window against the playout point
  always_comb begin
    baseSeq    = anchored ? nextSeq : wrSeq;
    seqDiff    = wrSeq - baseSeq;
    inWindow   = seqDiff < SEQ_W'(cfgDepth);
    locked     = playing && ((byteIdx != '0) || playTick);
    hitsHead   = anchored && locked && (seqDiff == '0);
    acceptable = inWindow && !hitsHead;
    doWrite    = wrValid && acceptable && !wrSlotValid;
    isDup      = wrValid && acceptable && wrSlotValid;
    isLate     = wrValid && !acceptable;
  end

  // Playout side
  always_comb begin
    halfDepth = cfgDepth >> 1;
    startLvl  = (halfDepth == '0) ? DEPTH_W'(1) : halfDepth;
    atHead    = (byteIdx == '0);
    missing   = atHead ? !playSlotValid : curMiss;
    underrun  = playing && playTick && atHead && !playSlotValid && (fillCnt == '0);
    stepping  = playing && playTick && !underrun;
    lastHit   = (LEN_W'(byteIdx) == cfgPayLen - LEN_W'(1));
    finishing = stepping && lastHit;
    lostEvt   = stepping && atHead && !playSlotValid;

    stb.wrEn  = doWrite;
    stb.clrEn = finishing && !missing;
    stb.outEn = playTick;
    if (!playing || underrun) stb.outSrc = SRC_COND;
    else if (missing)         stb.outSrc = cfgRepeat ? SRC_LAST : SRC_COND;
    else                      stb.outSrc = SRC_DATA;
  end

  assign wrSlot   = wrSeq[SLOT_W-1:0];
  assign playSlot = nextSeq[SLOT_W-1:0];
  assign byteSel  = byteIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextSeq  <= '0;
      anchored <= 1'b0;
      playing  <= 1'b0;
      curMiss  <= 1'b0;
      byteIdx  <= '0;
      fillCnt  <= '0;
    end else begin
      if (doWrite && !anchored) begin
        anchored <= 1'b1;
        nextSeq  <= wrSeq;
      end
      fillCnt <= fillCnt + DEPTH_W'(doWrite) - DEPTH_W'(stb.clrEn);
      if (stepping) begin
        if (atHead) curMiss <= !playSlotValid;
        if (finishing) begin
          byteIdx <= '0;
          nextSeq <= nextSeq + SEQ_W'(1);
        end else begin
          byteIdx <= byteIdx + BYTE_W'(1);
        end
      end
      if (underrun) playing <= 1'b0;
      else if (!playing && fillCnt != '0 && fillCnt >= startLvl) playing <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLost  <= '0;
      cntLate  <= '0;
      cntDup   <= '0;
      cntUnder <= '0;
    end else begin
      if (lostEvt)  cntLost  <= cntLost  + CNT_W'(1);
      if (isLate)   cntLate  <= cntLate  + CNT_W'(1);
      if (isDup)    cntDup   <= cntDup   + CNT_W'(1);
      if (underrun) cntUnder <= cntUnder + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pkt_jitter_buffer.sv
module pkt_jitter_buffer
  import pkt_jitter_buffer_pkg::*;
#(
  parameter int SLOTS     = 16,
  parameter int PAY_BYTES = 8,
  parameter int CNT_W     = 16,
  localparam int SEQ_W    = 16,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BYTE_W   = (PAY_BYTES > 1) ? $clog2(PAY_BYTES) : 1,
  localparam int DEPTH_W  = $clog2(SLOTS + 1),
  localparam int LEN_W    = $clog2(PAY_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DEPTH_W-1:0]     cfgDepth,
  input  logic [LEN_W-1:0]       cfgPayLen,
  input  logic                   cfgRepeat,
  input  logic [7:0]             cfgCondByte,
  input  logic                   wrValid,
  input  logic [SEQ_W-1:0]       wrSeq,
  input  logic [PAY_BYTES*8-1:0] wrPayload,
  input  logic                   playTick,
  output logic                   outValid,
  output logic [7:0]             outByte,
  output logic [CNT_W-1:0]       cntLost,
  output logic [CNT_W-1:0]       cntLate,
  output logic [CNT_W-1:0]       cntDup,
  output logic [CNT_W-1:0]       cntUnder
);

  stb_t               stb;
  logic [SLOT_W-1:0]  wrSlot, playSlot;
  logic [BYTE_W-1:0]  byteSel;
  logic               wrSlotValid, playSlotValid;
  logic               playing;
  logic [DEPTH_W-1:0] fillCnt;

  pkt_jitter_buffer_ctrl #(
    .SLOTS(SLOTS), .PAY_BYTES(PAY_BYTES), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgDepth(cfgDepth), .cfgPayLen(cfgPayLen), .cfgRepeat(cfgRepeat),
    .wrValid(wrValid), .wrSeq(wrSeq), .playTick(playTick),
    .wrSlotValid(wrSlotValid), .playSlotValid(playSlotValid),
    .stb(stb), .wrSlot(wrSlot), .playSlot(playSlot), .byteSel(byteSel),
    .playing(playing), .fillCnt(fillCnt),
    .cntLost(cntLost), .cntLate(cntLate), .cntDup(cntDup), .cntUnder(cntUnder)
  );

  pkt_jitter_buffer_data #(
    .SLOTS(SLOTS), .PAY_BYTES(PAY_BYTES)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrSlot(wrSlot), .wrWord(wrPayload),
    .playSlot(playSlot), .byteSel(byteSel), .condByte(cfgCondByte),
    .wrSlotValid(wrSlotValid), .playSlotValid(playSlotValid),
    .outValid(outValid), .outByte(outByte)
  );

endmodule

// File: rtl/pkt_jitter_buffer_chk.sv
module pkt_jitter_buffer_chk #(
  parameter int DEPTH_W = 5,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [DEPTH_W-1:0] cfgDepth,
  input logic [7:0]         cfgCondByte,
  input logic               playTick,
  input logic               outValid,
  input logic [7:0]         outByte,
  input logic               playing,
  input logic [DEPTH_W-1:0] fillCnt,
  input logic [CNT_W-1:0]   cntLate,
  input logic [CNT_W-1:0]   cntDup,
  input logic [CNT_W-1:0]   cntUnder
);

  // R6: every strobe yields exactly one output byte on the next clock
  p_tick_out_r6: assert property (@(posedge clk) disable iff (!rstN)
    playTick |=> outValid);
  p_out_from_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(playTick));

  // R5: strobes during prefill give the conditioning byte
  p_prefill_cond_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!playing && playTick) |=> (outByte == $past(cfgCondByte)));

  // R3: the window never holds more packets than the configured depth
  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= cfgDepth);

  // R9: an underrun always drops back into prefill
  p_under_prefill_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cntUnder != $past(cntUnder)) |-> !playing);

  // R4: one arrival is either a duplicate or a window drop, never both
  p_drop_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cntDup != $past(cntDup), cntLate != $past(cntLate)}));

endmodule

bind pkt_jitter_buffer pkt_jitter_buffer_chk #(
  .DEPTH_W(DEPTH_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgDepth(cfgDepth), .cfgCondByte(cfgCondByte),
  .playTick(playTick), .outValid(outValid), .outByte(outByte),
  .playing(playing), .fillCnt(fillCnt),
  .cntLate(cntLate), .cntDup(cntDup), .cntUnder(cntUnder)
);

// File: tb/pkt_jitter_buffer_bench.sv
`timescale 1ns/1ps
module pkt_jitter_buffer_bench;
  localparam int SLOTS = 16, PAY = 8, CNT_W = 16;
  localparam int DW = $clog2(SLOTS + 1), LW = $clog2(PAY + 1);
  localparam logic [7:0] COND = 8'hA5;

  logic clk = 1'b0, rstN = 1'b0;
  logic [DW-1:0] cfgDepth = DW'(4);
  logic [LW-1:0] cfgPayLen = LW'(2);
  logic cfgRepeat = 1'b0;
  logic [7:0] cfgCondByte = COND;
  logic wrValid = 1'b0, playTick = 1'b0;
  logic [15:0] wrSeq = '0;
  logic [PAY*8-1:0] wrPayload = '0;
  logic outValid;
  logic [7:0] outByte;
  logic [CNT_W-1:0] cntLost, cntLate, cntDup, cntUnder;

  always #2.5 clk = ~clk;

  pkt_jitter_buffer #(.SLOTS(SLOTS), .PAY_BYTES(PAY), .CNT_W(CNT_W)) u_pkt_jitter_buffer (
    .clk(clk), .rstN(rstN), .cfgDepth(cfgDepth), .cfgPayLen(cfgPayLen),
    .cfgRepeat(cfgRepeat), .cfgCondByte(cfgCondByte), .wrValid(wrValid),
    .wrSeq(wrSeq), .wrPayload(wrPayload), .playTick(playTick),
    .outValid(outValid), .outByte(outByte), .cntLost(cntLost),
    .cntLate(cntLate), .cntDup(cntDup), .cntUnder(cntUnder)
  );

  int nChecks = 0, nFails = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic [7:0] monExp;
  string monTag;

  function automatic logic [7:0] byteOf(input logic [15:0] s, input int i);
    return s[7:0] ^ s[15:8] ^ (8'h3C + 8'(i * 17));
  endfunction

  function automatic logic [PAY*8-1:0] mkWord(input logic [15:0] s);
    logic [PAY*8-1:0] w;
    for (int i = 0; i < PAY; i++) w[i*8 +: 8] = byteOf(s, i);
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sendPkt(input logic [15:0] s, input logic [PAY*8-1:0] w);
    @(negedge clk);
    wrValid = 1'b1; wrSeq = s; wrPayload = w;
    @(negedge clk);
    wrValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic tickExp(input logic [7:0] e, input string tag);
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    playTick = 1'b1;
    @(negedge clk);
    playTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic playPkt(input logic [15:0] s, input int len, input string tag);
    for (int i = 0; i < len; i++) tickExp(byteOf(s, i), tag);
  endtask

  task automatic doReset(input int depth, input int len, input logic rep);
    @(negedge clk);
    rstN = 1'b0;
    cfgDepth = DW'(depth); cfgPayLen = LW'(len); cfgRepeat = rep;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Monitor: pop the scoreboard whenever a byte comes out
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R6 unexpected byte: actual %0h expected none", outByte);
      end else begin
        monExp = expQ.pop_front();
        monTag = tagQ.pop_front();
        check(monTag, {24'h0, outByte}, {24'h0, monExp});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset(4, 2, 1'b0);
    check("R1 outValid after reset", {31'h0, outValid}, 0);
    check("R1 counters after reset", {cntLost, cntLate} | {cntDup, cntUnder}, 0);
    tickExp(COND, "R5 prefill with nothing buffered");

    // R2 reorder: 100, 102, 101
    sendPkt(16'd100, mkWord(16'd100));
    tickExp(COND, "R5 prefill below half depth");
    sendPkt(16'd102, mkWord(16'd102));
    sendPkt(16'd101, mkWord(16'd101));
    playPkt(16'd100, 2, "R2 R6 in-order play 100");
    playPkt(16'd101, 2, "R2 reordered 101");
    playPkt(16'd102, 2, "R2 reordered 102");

    // R3 window on both sides of next=103
    sendPkt(16'd102, mkWord(16'd102));
    sendPkt(16'd107, mkWord(16'd107));
    check("R3 late count", {16'h0, cntLate}, 2);

    // R7 lost 103, R8 conditioning mode
    sendPkt(16'd104, mkWord(16'd104));
    sendPkt(16'd105, mkWord(16'd105));
    tickExp(COND, "R7 R8 concealed byte 0");
    tickExp(COND, "R7 R8 concealed byte 1");
    playPkt(16'd104, 2, "R7 after loss 104");
    playPkt(16'd105, 2, "R7 after loss 105");
    check("R7 lost count", {16'h0, cntLost}, 1);

    // R9 underrun then prefill
    tickExp(COND, "R9 underrun byte");
    check("R9 underrun count", {16'h0, cntUnder}, 1);
    tickExp(COND, "R9 back in prefill");
    check("R9 prefill is not another underrun", {16'h0, cntUnder}, 1);
    sendPkt(16'd106, mkWord(16'd106));
    tickExp(COND, "R9 R5 waits for half fill again");
    sendPkt(16'd107, mkWord(16'd107));
    playPkt(16'd106, 2, "R9 resumes at same sequence 106");
    playPkt(16'd107, 2, "R9 resumes 107");

    // R4 duplicate keeps the original payload
    sendPkt(16'd108, mkWord(16'd108));
    sendPkt(16'd108, ~mkWord(16'd108));
    check("R4 duplicate count", {16'h0, cntDup}, 1);
    sendPkt(16'd109, mkWord(16'd109));
    playPkt(16'd108, 2, "R4 original payload kept");
    playPkt(16'd109, 2, "R4 next packet");

    // R8 repeat-last concealment
    @(negedge clk); cfgRepeat = 1'b1;
    sendPkt(16'd111, mkWord(16'd111));
    tickExp(byteOf(16'd109, 1), "R8 repeat last byte 0");
    tickExp(byteOf(16'd109, 1), "R8 repeat last byte 1");
    playPkt(16'd111, 2, "R8 data after repeat");
    check("R7 lost count second", {16'h0, cntLost}, 2);

    // R10 arrival of the packet being concealed
    sendPkt(16'd113, mkWord(16'd113));
    tickExp(byteOf(16'd111, 1), "R10 concealment started");
    sendPkt(16'd112, mkWord(16'd112));
    check("R10 head collision counted late", {16'h0, cntLate}, 3);
    check("R10 not a duplicate", {16'h0, cntDup}, 1);
    tickExp(byteOf(16'd111, 1), "R10 concealment continues");
    playPkt(16'd113, 2, "R10 next packet plays");
    check("R7 lost count third", {16'h0, cntLost}, 3);

    // R11 wrap with depth 8, length 3, repeat mode
    doReset(8, 3, 1'b1);
    check("R1 counters after second reset", {cntLost, cntLate} | {cntDup, cntUnder}, 0);
    sendPkt(16'hFFFE, mkWord(16'hFFFE));
    sendPkt(16'hFFFF, mkWord(16'hFFFF));
    sendPkt(16'h0001, mkWord(16'h0001));
    sendPkt(16'h000A, mkWord(16'h000A));
    check("R11 R3 far-ahead across wrap dropped", {16'h0, cntLate}, 1);
    sendPkt(16'h0002, mkWord(16'h0002));
    playPkt(16'hFFFE, 3, "R11 R6 three-byte payload FFFE");
    playPkt(16'hFFFF, 3, "R11 payload FFFF");
    for (int i = 0; i < 3; i++) tickExp(byteOf(16'hFFFF, 2), "R11 R8 concealed 0000");
    playPkt(16'h0001, 3, "R11 payload 0001");
    playPkt(16'h0002, 3, "R11 payload 0002");
    check("R11 lost across wrap", {16'h0, cntLost}, 1);

    repeat (4) @(negedge clk);
    check("R6 every expected byte produced", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule